// File: doc/BRIEF.md
# Typed-Event Order Checker

This block follows a single signal whose activity is not given as a level but as a stream of typed events. Each event is one of five kinds: an ordinary rising edge, an ordinary falling edge, a move into an unknown value, a settle to a known 1, and a settle to a known 0. On each clock where the strobe is high, the checker reads one event code. It tests whether that kind may follow the current level of the signal, then updates the level to match. The level is one of three values: high, low or unknown.

The first illegal event sets a violation flag, which stays set until reset. The code of that event is kept for diagnosis. The tracked level keeps following every event that has a defined meaning, so the checker stays in step with the signal after a fault. Several instances, one for each handshake wire, can watch the control signals of a clockless datapath, either in simulation or in a debug fabric on the die. Timing checks and checks between two signals belong elsewhere.

Top module: `evchk_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sig_state` reads 2'b00 (unknown), `viol` reads 0 and `viol_code` reads 0. The level encoding is 2'b00 unknown, 2'b01 low and 2'b10 high.
- R2: Event codes are 0 rise, 1 fall, 2 to-unknown, 3 settle-high and 4 settle-low. At the unknown level, only codes 3 and 4 are legal. Codes 0, 1 and 2 there are violations.
- R3: At the high level, reached by a rise or a settle-high, only codes 1 and 2 are legal. Codes 0, 3 and 4 are violations.
- R4: At the low level, reached by a fall or a settle-low, only codes 0 and 2 are legal. Codes 1, 3 and 4 are violations.
- R5: Any code above 4 is a violation at every level and leaves `sig_state` unchanged.
- R6: An accepted event with code 0 or 3 makes the level high. Code 1 or 4 makes it low, and code 2 makes it unknown. This holds whether the event was legal or not.
- R7: Once `viol` is 1, it stays 1 until reset, whatever events follow.
- R8: `viol_code` holds the code of the first violation since reset. Later violations do not overwrite it.
- R9: With `ev_vld` low, `ev_code` has no effect: neither `sig_state` nor `viol` nor `viol_code` changes.
- R10: One event is taken at each rising clock edge where `ev_vld` is 1. Its effect on all three outputs is visible right after that same edge, so back-to-back events on consecutive cycles are each checked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_vld | input | 1 | Event strobe; one event is taken per clock while it is high |
| ev_code | input | CODE_W | Event kind code (0 to 4 defined) |
| viol | output | 1 | Sticky ordering-violation flag |
| viol_code | output | CODE_W | Code of the first offending event |
| sig_state | output | 2 | Tracked level: 00 unknown, 01 low, 10 high |

## Verification
The bench first walks a legal cycle through all three levels, using both the edge kinds and the settle kinds. This shows that a settle-high and a rise lead to the same set of legal successors. Each level is then given one of its forbidden codes, plus reserved codes 5 to 7, from a fresh reset. This separates a wrong legality table from a wrong next-level table, because the tracked level must still move on an illegal event. A second violation after the first shows whether the stored code is the first or the latest. Idle cycles carrying reserved or illegal codes show that the strobe truly gates the check.

// File: rtl/evchk_pkg.sv
package evchk_pkg;

   // Tracked level of the watched signal
   typedef enum logic [1:0] {
      LV_UNDEF = 2'b00,
      LV_LOW   = 2'b01,
      LV_HIGH  = 2'b10
   } level_e;

   // Event kinds; numeric values are the wire codes
   typedef enum logic [2:0] {
      EK_RISE  = 3'd0,
      EK_FALL  = 3'd1,
      EK_UNDEF = 3'd2,
      EK_DEFH  = 3'd3,
      EK_DEFL  = 3'd4
   } ev_kind_e;

   localparam int unsigned KIND_W   = 3;
   localparam int unsigned KIND_MAX = 4;

   typedef struct packed {
      logic     known;
      ev_kind_e kind;
   } ev_dec_t;

endpackage

// File: rtl/evchk_decode.sv
module evchk_decode
   import evchk_pkg::*;
#(
   parameter int unsigned CODE_W = 3
) (
   input  logic [CODE_W-1:0] code,
   output ev_dec_t           dec
);

   logic                upper_zero;
   logic [KIND_W-1:0]   low_bits;

   assign low_bits = code[KIND_W-1:0];

   generate
      if (CODE_W > KIND_W) begin : g_wide
         assign upper_zero = ~|code[CODE_W-1:KIND_W];
      end else begin : g_narrow
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      dec.known = upper_zero && (low_bits <= KIND_W'(KIND_MAX));
      dec.kind  = dec.known ? ev_kind_e'(low_bits) : EK_RISE;
   end

endmodule

// File: rtl/evchk_rules.sv
module evchk_rules
   import evchk_pkg::*;
(
   input  level_e  cur,
   input  ev_dec_t ev,
   output logic    legal,
   output level_e  nxt
);

   // Legal successors depend only on the level; settle and edge
   // events that reach the same level share one successor set.
   always_comb begin
      legal = 1'b0;
      if (ev.known) begin
         unique case (cur)
            LV_UNDEF: legal = (ev.kind == EK_DEFH) || (ev.kind == EK_DEFL);
            LV_HIGH:  legal = (ev.kind == EK_FALL) || (ev.kind == EK_UNDEF);
            LV_LOW:   legal = (ev.kind == EK_RISE) || (ev.kind == EK_UNDEF);
            default:  legal = 1'b0;
         endcase
      end
   end

   always_comb begin
      nxt = cur;
      if (ev.known) begin
         unique case (ev.kind)
            EK_RISE, EK_DEFH: nxt = LV_HIGH;
            EK_FALL, EK_DEFL: nxt = LV_LOW;
            EK_UNDEF:         nxt = LV_UNDEF;
            default:          nxt = cur;
         endcase
      end
   end

endmodule

// File: rtl/evchk_track.sv
module evchk_track
   import evchk_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   take,
   input  level_e nxt,
   output level_e cur
);

   always_ff @(posedge clk) begin
      if (!rst_n)    cur <= LV_UNDEF;
      else if (take) cur <= nxt;
   end

endmodule

// File: rtl/evchk_flag.sv
module evchk_flag #(
   parameter int unsigned CODE_W     = 3,
   parameter bit          KEEP_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [CODE_W-1:0] code,
   output logic              flag,
   output logic [CODE_W-1:0] flag_code
);

   logic load_code;

   generate
      if (KEEP_FIRST) begin : g_first
         assign load_code = hit && !flag;
      end else begin : g_latest
         assign load_code = hit;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag      <= 1'b0;
         flag_code <= '0;
      end else begin
         if (hit)       flag      <= 1'b1;
         if (load_code) flag_code <= code;
      end
   end

endmodule

// File: rtl/evchk_top.sv
module evchk_top
   import evchk_pkg::*;
#(
   parameter int unsigned CODE_W     = 3,
   parameter bit          KEEP_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_vld,
   input  logic [CODE_W-1:0] ev_code,
   output logic              viol,
   output logic [CODE_W-1:0] viol_code,
   output logic [1:0]        sig_state
);

   generate
      if (CODE_W < KIND_W) begin : g_bad_code_w
         $error("evchk_top: CODE_W must be at least 3");
      end
   endgenerate

   ev_dec_t dec;
   level_e  cur_lv;
   level_e  nxt_lv;
   logic    legal;
   logic    take;
   logic    hit;

   evchk_decode #(.CODE_W(CODE_W)) u_decode (
      .code (ev_code),
      .dec  (dec)
   );

   evchk_rules u_rules (
      .cur   (cur_lv),
      .ev    (dec),
      .legal (legal),
      .nxt   (nxt_lv)
   );

   assign take = ev_vld && dec.known;
   assign hit  = ev_vld && !legal;

   evchk_track u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .nxt   (nxt_lv),
      .cur   (cur_lv)
   );

   evchk_flag #(.CODE_W(CODE_W), .KEEP_FIRST(KEEP_FIRST)) u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .code      (ev_code),
      .flag      (viol),
      .flag_code (viol_code)
   );

   assign sig_state = cur_lv;

endmodule

// File: rtl/evchk_props.sv
module evchk_props #(
   parameter int unsigned CODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_vld,
   input logic [CODE_W-1:0] ev_code,
   input logic              viol,
   input logic [CODE_W-1:0] viol_code,
   input logic [1:0]        sig_state
);

   // R7
   sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol |=> viol);

   // R8
   first_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol |=> $stable(viol_code));

   // R9
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_vld |=> $stable(sig_state));

   // R9
   idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_vld && !viol) |=> !viol);

   // R5
   reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_vld && (ev_code > CODE_W'(4))) |=> (viol && $stable(sig_state)));

   // R2
   undef_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_vld && sig_state == 2'b00 && ev_code < CODE_W'(3)) |=> viol);

   // R6
   rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_vld && ev_code == CODE_W'(0)) |=> (sig_state == 2'b10));

   // R6
   level_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sig_state != 2'b11);

endmodule

bind evchk_top evchk_props #(.CODE_W(CODE_W)) u_props (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_vld    (ev_vld),
   .ev_code   (ev_code),
   .viol      (viol),
   .viol_code (viol_code),
   .sig_state (sig_state)
);

// File: tb/test_evchk_top.sv
module test_evchk_top;

   localparam int unsigned CODE_W   = 3;
   localparam time         CLK_PER  = 10ns;
   localparam int unsigned WD_LIMIT = 5000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ev_vld = 1'b0;
   logic [CODE_W-1:0] ev_code = '0;
   logic              viol;
   logic [CODE_W-1:0] viol_code;
   logic [1:0]        sig_state;

   evchk_top #(.CODE_W(CODE_W)) i_evchk_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_vld    (ev_vld),
      .ev_code   (ev_code),
      .viol      (viol),
      .viol_code (viol_code),
      .sig_state (sig_state)
   );

   always #(CLK_PER/2) clk = ~clk;

   typedef struct {
      logic              viol;
      logic [CODE_W-1:0] code;
      logic [1:0]        lvl;
      string             req;
   } exp_t;

   exp_t exp_q[$];

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Reference model state
   logic [1:0]        m_lvl;
   logic              m_viol;
   logic [CODE_W-1:0] m_code;

   function automatic bit ok_next(input logic [1:0] lvl, input int c);
      case (lvl)
         2'b00:   return (c == 3) || (c == 4);
         2'b10:   return (c == 1) || (c == 2);
         2'b01:   return (c == 0) || (c == 2);
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [1:0] lvl_after(input logic [1:0] lvl, input int c);
      case (c)
         0, 3:    return 2'b10;
         1, 4:    return 2'b01;
         2:       return 2'b00;
         default: return lvl;
      endcase
   endfunction

   task automatic compare(input logic ev, input logic [CODE_W-1:0] ec,
                          input logic [1:0] el, input string req);
      n_chk++;
      if (viol !== ev || viol_code !== ec || sig_state !== el) begin
         n_fail++;
         $display("FAIL %s: viol=%0b code=%0d state=%b, expected viol=%0b code=%0d state=%b",
                  req, viol, viol_code, sig_state, ev, ec, el);
      end
   endtask

   task automatic do_reset(input string req);
      @(negedge clk);
      rst_n  = 1'b0;
      ev_vld = 1'b0;
      repeat (2) @(negedge clk);
      m_lvl = 2'b00; m_viol = 1'b0; m_code = '0;
      compare(1'b0, '0, 2'b00, req);
      rst_n = 1'b1;
      @(negedge clk);
      compare(1'b0, '0, 2'b00, req);
   endtask

   // Driver: drive on falling edge, push expectation after the sampling edge
   task automatic send(input logic vld, input int c, input string req);
      exp_t e;
      @(negedge clk);
      ev_vld  = vld;
      ev_code = CODE_W'(c);
      if (vld) begin
         if (!ok_next(m_lvl, c)) begin
            if (!m_viol) m_code = CODE_W'(c);
            m_viol = 1'b1;
         end
         m_lvl = lvl_after(m_lvl, c);
      end
      e.viol = m_viol; e.code = m_code; e.lvl = m_lvl; e.req = req;
      @(posedge clk);
      #1;
      exp_q.push_back(e);
   endtask

   // Monitor: compare one result per falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         compare(e.viol, e.code, e.lvl, e.req);
      end
   end

   task automatic drain;
      @(negedge clk);
      ev_vld = 1'b0;
      while (exp_q.size() > 0) @(negedge clk);
   endtask

   initial begin
      m_lvl = 2'b00; m_viol = 1'b0; m_code = '0;
      do_reset("R1");

      // Idle with illegal/reserved codes
      send(1'b0, 0, "R9");
      send(1'b0, 5, "R9");
      // Legal tour through all levels, back-to-back
      send(1'b1, 3, "R2 R10");
      send(1'b1, 1, "R3 R10");
      send(1'b1, 0, "R4 R10");
      send(1'b1, 2, "R3 R6");
      send(1'b1, 4, "R2 R6");
      send(1'b1, 2, "R4");
      send(1'b0, 1, "R9");
      send(1'b1, 3, "R2");
      send(1'b1, 1, "R3");
      // Violation at low level, then second violation, then legal traffic
      send(1'b1, 1, "R4 R6");
      send(1'b1, 3, "R8 R6");
      send(1'b1, 1, "R7");
      send(1'b1, 0, "R7");
      send(1'b0, 6, "R9 R7");
      drain();

      do_reset("R1 R7");
      send(1'b1, 0, "R2 R6");
      send(1'b1, 5, "R8 R5");
      drain();

      do_reset("R1");
      send(1'b1, 6, "R5");
      send(1'b1, 4, "R5 R6");
      drain();

      do_reset("R1");
      send(1'b1, 4, "R2");
      send(1'b1, 7, "R5");
      drain();

      do_reset("R1");
      send(1'b1, 3, "R2");
      send(1'b1, 0, "R3 R6");
      drain();

      do_reset("R1");
      send(1'b1, 4, "R2");
      send(1'b1, 3, "R4 R6");
      drain();

      do_reset("R1");
      send(1'b1, 2, "R2 R6");
      drain();

      do_reset("R1");
      send(1'b1, 3, "R2");
      send(1'b1, 4, "R3 R6");
      drain();

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < WD_LIMIT) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual cycles=%0d expected fewer than %0d",
                  cyc, WD_LIMIT);
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule